// File: doc/BRIEF.md
# Dual-channel DAC command register interface

This block is the register side of a two-channel 12-bit converter that sits behind a two-wire serial bus. The bit-level serializer is outside the block. It delivers each transaction as a parallel stream: a start flag, a stop flag and a byte-valid strobe with its byte. A write transaction carries a device address byte, then one or more groups. Each group is a command byte followed by a high and a low data byte. The block decodes the operation and channel fields of each command and keeps two registers per channel. The input register is the staging stage. The converter register is the stage that drives the output code.

The converter registers can be loaded in several ways. A command can load them. A level on the load pin (active low) can copy every input register across at once. A per-channel transparency mask can make a channel follow its input register on every edge. An active-low clear pin forces both output codes to zero at once and empties the converter registers. The input registers keep their contents through a clear. A reset command returns all of the state to its defaults. A reference-enable flag is stored and brought out; nothing else in the block uses it.

Top module: `dual_dac_cmd_if`

## Requirements
- R1: After `rst_n` is released, `code_a`, `code_b` and `ref_en` are 0 and the transparency mask is 0.
- R2: The only address byte accepted after a start flag is 0x18 (7-bit address 0x0C, write). Any other value, including 0x19, causes every byte up to the next start flag to be ignored. A start flag always begins a new address phase.
- R3: Command byte bits: bit 6 is the multi-group flag, bits 5:3 are the operation and bits 2:0 are the channel; bit 7 is ignored. The data word is {high byte, low byte[7:4]}, and low byte bits 3:0 do not affect the code. A group takes effect on the clock edge that accepts its low data byte.
- R4: Operation 000 writes the input register of the selected channel(s). It does not load a converter register.
- R5: Operation 001 copies the input register to the converter register for the selected channel(s). The data bytes are consumed but not used.
- R6: Operation 010 writes the input register of the selected channel(s) and, on the same edge, loads both converter registers from the updated input registers.
- R7: Operation 011 writes and loads the selected channel(s) on the same edge.
- R8: Channel code 000 is channel A, 001 is channel B and 111 is both. Under any other code, operations 000 to 011 have no effect.
- R9: While `ldac_n` is high and no command or mask applies, the outputs hold. On every edge where `ldac_n` is low, each converter register loads its input register, including a value written on that same edge.
- R10: While `clr_n` is low, both output codes read 0 without waiting for a clock edge, and the converter registers are cleared on each edge. The input registers keep their contents. After release, the codes stay 0 until a converter register is loaded again.
- R11: Operation 101 clears both input registers, both converter registers, the mask and the reference flag on the executing edge.
- R12: Operation 110 loads the mask from low byte bit 0 (channel A) and bit 1 (channel B). Starting with the next edge, a masked channel loads its converter register from its input register on every edge, whatever the level of `ldac_n`.
- R13: Operation 111 sets `ref_en` to low byte bit 0. Operation 100 changes nothing that is visible.
- R14: When the multi-group flag is 1, groups keep being accepted until the stop flag. When it is 0, bytes after the first group are ignored. A group cut short by a stop or start flag is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_start | input | 1 | Start condition seen, one-cycle pulse |
| bus_stop | input | 1 | Stop condition seen, one-cycle pulse |
| byte_vld | input | 1 | `byte_data` holds a received byte this cycle |
| byte_data | input | 8 | Received byte |
| ldac_n | input | 1 | Load pin, low loads all converter registers |
| clr_n | input | 1 | Clear pin, low forces both codes to zero |
| code_a | output | DATA_W | Channel A output code |
| code_b | output | DATA_W | Channel B output code |
| ref_en | output | 1 | Stored reference-enable flag |

## Verification
A command that writes or loads a converter register can land on the same edge as a low `ldac_n` or a low `clr_n`. The bench provokes the first case by holding the load pin low for half of the sweep over all operation and channel codes, so every group executes with the pin low. It provokes the second by sending a write-and-load group while the clear pin is low. The results are judged against a per-edge reference model in which a clear overrides the load and the load pin sees the value written on that same edge. The model is checked after each executing edge and again after the clear is released.

// File: rtl/dual_dac_pkg.sv
`timescale 1ns/1ps
package dual_dac_pkg;

    localparam int NCH = 2;
    localparam logic [2:0] CHAN_ALL = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_CMD  = 3'd2,
        ST_HI   = 3'd3,
        ST_LO   = 3'd4
    } frame_st_e;

    typedef enum logic [2:0] {
        OP_WR_IN      = 3'b000,
        OP_UPD        = 3'b001,
        OP_WR_UPD_ALL = 3'b010,
        OP_WR_UPD     = 3'b011,
        OP_POWER      = 3'b100,
        OP_RESET      = 3'b101,
        OP_MASK       = 3'b110,
        OP_REF        = 3'b111
    } op_e;

    typedef struct packed {
        logic [NCH-1:0] wr;
        logic [NCH-1:0] upd;
        logic           do_reset;
        logic           set_mask;
        logic           set_ref;
    } action_t;

endpackage

// File: rtl/dual_dac_frame.sv
`timescale 1ns/1ps
module dual_dac_frame
    import dual_dac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h0C
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_start,
    input  logic      bus_stop,
    input  logic      byte_vld,
    input  logic [7:0] byte_data,
    output logic      exec_o,
    output op_e       op_o,
    output logic [2:0] chan_o,
    output logic      multi_o,
    output logic [7:0] hi_o,
    output frame_st_e state_o
);

    localparam logic [7:0] WR_ADDR_BYTE = {DEV_ADDR, 1'b0};

    typedef struct packed {
        frame_st_e  st;
        logic [6:0] cmd;
        logic [7:0] hi;
    } frame_t;

    frame_t f_d, f_q;
    logic   exec_d;

    always_comb begin
        f_d    = f_q;
        exec_d = 1'b0;
        if (bus_start) begin
            f_d.st = ST_ADDR;
        end else if (bus_stop) begin
            f_d.st = ST_IDLE;
        end else if (byte_vld) begin
            case (f_q.st)
                ST_ADDR: f_d.st = (byte_data == WR_ADDR_BYTE) ? ST_CMD : ST_IDLE;
                ST_CMD: begin
                    f_d.cmd = byte_data[6:0];
                    f_d.st  = ST_HI;
                end
                ST_HI: begin
                    f_d.hi = byte_data;
                    f_d.st = ST_LO;
                end
                ST_LO: begin
                    exec_d = 1'b1;
                    f_d.st = f_q.cmd[6] ? ST_CMD : ST_IDLE;
                end
                default: f_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign exec_o  = exec_d;
    assign op_o    = op_e'(f_q.cmd[5:3]);
    assign chan_o  = f_q.cmd[2:0];
    assign multi_o = f_q.cmd[6];
    assign hi_o    = f_q.hi;
    assign state_o = f_q.st;

endmodule

// File: rtl/dual_dac_decode.sv
`timescale 1ns/1ps
module dual_dac_decode
    import dual_dac_pkg::*;
(
    input  logic       exec_i,
    input  op_e        op_i,
    input  logic [2:0] chan_i,
    output action_t    act_o
);

    logic [NCH-1:0] sel;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            sel[i] = (chan_i == 3'(i)) || (chan_i == CHAN_ALL);
        end
    end

    always_comb begin
        act_o = '0;
        if (exec_i) begin
            case (op_i)
                OP_WR_IN: act_o.wr = sel;
                OP_UPD:   act_o.upd = sel;
                OP_WR_UPD_ALL: begin
                    act_o.wr  = sel;
                    act_o.upd = {NCH{|sel}};
                end
                OP_WR_UPD: begin
                    act_o.wr  = sel;
                    act_o.upd = sel;
                end
                OP_RESET: act_o.do_reset = 1'b1;
                OP_MASK:  act_o.set_mask = 1'b1;
                OP_REF:   act_o.set_ref  = 1'b1;
                default:  act_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/dual_dac_regs.sv
`timescale 1ns/1ps
module dual_dac_regs
    import dual_dac_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_n,
    input  logic                           ldac_n,
    input  action_t                        act_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic [NCH-1:0]                 mask_i,
    input  logic                           ref_i,
    output logic [NCH-1:0][DATA_W-1:0]     dac_o,
    output logic [NCH-1:0][DATA_W-1:0]     inp_o,
    output logic [NCH-1:0]                 mask_o,
    output logic                           ref_o
);

    typedef struct packed {
        logic [NCH-1:0][DATA_W-1:0] inp;
        logic [NCH-1:0][DATA_W-1:0] dac;
        logic [NCH-1:0]             mask;
        logic                       ref_en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int ch = 0; ch < NCH; ch++) begin
            if (act_i.wr[ch]) begin
                r_d.inp[ch] = wdata_i;
            end
        end
        if (act_i.set_mask) begin
            r_d.mask = mask_i;
        end
        if (act_i.set_ref) begin
            r_d.ref_en = ref_i;
        end
        for (int ch = 0; ch < NCH; ch++) begin
            if (act_i.upd[ch] || !ldac_n || r_q.mask[ch]) begin
                r_d.dac[ch] = r_d.inp[ch];
            end
            if (!clr_n) begin
                r_d.dac[ch] = '0;
            end
        end
        if (act_i.do_reset) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dac_o  = r_q.dac;
    assign inp_o  = r_q.inp;
    assign mask_o = r_q.mask;
    assign ref_o  = r_q.ref_en;

endmodule

// File: rtl/dual_dac_cmd_if.sv
`timescale 1ns/1ps
module dual_dac_cmd_if
    import dual_dac_pkg::*;
#(
    parameter int         DATA_W   = 12,
    parameter logic [6:0] DEV_ADDR = 7'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              ldac_n,
    input  logic              clr_n,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              ref_en
);

    localparam int WORD_W = 16;
    localparam int PAD_W  = WORD_W - DATA_W;

    logic                       exec;
    op_e                        op;
    logic [2:0]                 chan;
    logic                       multi;
    logic [7:0]                 hi;
    frame_st_e                  fstate;
    action_t                    act;
    logic [NCH-1:0][DATA_W-1:0] dac;
    logic [NCH-1:0][DATA_W-1:0] inp;
    logic [NCH-1:0]             mask;
    logic [NCH-1:0][DATA_W-1:0] code_g;

    dual_dac_frame #(.DEV_ADDR(DEV_ADDR)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .exec_o    (exec),
        .op_o      (op),
        .chan_o    (chan),
        .multi_o   (multi),
        .hi_o      (hi),
        .state_o   (fstate)
    );

    dual_dac_decode u_decode (
        .exec_i (exec),
        .op_i   (op),
        .chan_i (chan),
        .act_o  (act)
    );

    dual_dac_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .ldac_n  (ldac_n),
        .act_i   (act),
        .wdata_i (DATA_W'({hi, byte_data} >> PAD_W)),
        .mask_i  (byte_data[NCH-1:0]),
        .ref_i   (byte_data[0]),
        .dac_o   (dac),
        .inp_o   (inp),
        .mask_o  (mask),
        .ref_o   (ref_en)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign code_g[g] = clr_n ? dac[g] : '0;
    end

    assign code_a = code_g[0];
    assign code_b = code_g[1];

endmodule

// File: rtl/dual_dac_cmd_if_chk.sv
`timescale 1ns/1ps
module dual_dac_cmd_if_chk
    import dual_dac_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_n,
    input  logic                       ldac_n,
    input  logic                       bus_start,
    input  logic                       exec,
    input  logic                       multi,
    input  frame_st_e                  fstate,
    input  logic [DATA_W-1:0]          code_a,
    input  logic [DATA_W-1:0]          code_b,
    input  logic [NCH-1:0][DATA_W-1:0] inp,
    input  logic [NCH-1:0]             mask,
    input  logic                       ref_en
);

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        $rose(rst_n) |-> (code_a == '0 && code_b == '0 && !ref_en && mask == '0)); // R1

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> fstate == ST_ADDR); // R2

    AST_SINGLE_GROUP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !multi) |=> fstate == ST_IDLE); // R14

    AST_MULTI_GROUP_MORE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && multi) |=> fstate == ST_CMD); // R14

    AST_LOAD_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_n && !exec && mask == '0) |=> (!clr_n || ($stable(code_a) && $stable(code_b)))); // R9

    AST_LOAD_PIN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldac_n && clr_n) |=> (!clr_n || (code_a == inp[0] && code_b == inp[1]))); // R9

    AST_CLEAR_RELEASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_n) |-> (code_a == '0 && code_b == '0)); // R10

    AST_MASK_FOLLOW_A: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[0] && clr_n) |=> (!clr_n || code_a == inp[0])); // R12

    AST_MASK_FOLLOW_B: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[1] && clr_n) |=> (!clr_n || code_b == inp[1])); // R12

endmodule

bind dual_dac_cmd_if dual_dac_cmd_if_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .ldac_n    (ldac_n),
    .bus_start (bus_start),
    .exec      (exec),
    .multi     (multi),
    .fstate    (fstate),
    .code_a    (code_a),
    .code_b    (code_b),
    .inp       (inp),
    .mask      (mask),
    .ref_en    (ref_en)
);

// File: tb/sim_dual_dac_cmd_if.sv
`timescale 1ns/1ps
module sim_dual_dac_cmd_if;

    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_start = 1'b0;
    logic          bus_stop = 1'b0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = 8'h00;
    logic          ldac_n = 1'b1;
    logic          clr_n = 1'b1;
    logic [DW-1:0] code_a;
    logic [DW-1:0] code_b;
    logic          ref_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_inp [2];
    logic [DW-1:0] m_dac [2];
    logic [1:0]    m_mask;
    logic          m_ref;

    always #2.5 clk = ~clk;

    dual_dac_cmd_if u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .ldac_n    (ldac_n),
        .clr_n     (clr_n),
        .code_a    (code_a),
        .code_b    (code_b),
        .ref_en    (ref_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        check(req, 32'(code_a), 32'(clr_n ? m_dac[0] : '0));
        check(req, 32'(code_b), 32'(clr_n ? m_dac[1] : '0));
        check(req, 32'(ref_en), 32'(m_ref));
    endtask

    // Reference model of one clock edge, written from the requirements.
    task automatic model_edge(input bit ex, input logic [7:0] cmd, input logic [7:0] hi,
                              input logic [7:0] lo);
        logic [1:0]    sel;
        logic [1:0]    wr;
        logic [1:0]    upd;
        logic [1:0]    old_mask;
        logic [DW-1:0] val;
        bit            rst_cmd;
        old_mask = m_mask;
        wr = 2'b00;
        upd = 2'b00;
        rst_cmd = 1'b0;
        val = {hi, lo[7:4]};
        if (ex) begin
            sel[0] = (cmd[2:0] == 3'd0) || (cmd[2:0] == 3'd7);
            sel[1] = (cmd[2:0] == 3'd1) || (cmd[2:0] == 3'd7);
            case (cmd[5:3])
                3'd0: wr = sel;
                3'd1: upd = sel;
                3'd2: begin wr = sel; upd = (sel != 2'b00) ? 2'b11 : 2'b00; end
                3'd3: begin wr = sel; upd = sel; end
                3'd5: rst_cmd = 1'b1;
                3'd6: m_mask = lo[1:0];
                3'd7: m_ref = lo[0];
                default: ;
            endcase
        end
        for (int ch = 0; ch < 2; ch++) begin
            if (wr[ch]) m_inp[ch] = val;
        end
        for (int ch = 0; ch < 2; ch++) begin
            if (upd[ch] || !ldac_n || old_mask[ch]) m_dac[ch] = m_inp[ch];
            if (!clr_n) m_dac[ch] = '0;
        end
        if (rst_cmd) begin
            m_inp[0] = '0; m_inp[1] = '0;
            m_dac[0] = '0; m_dac[1] = '0;
            m_mask = 2'b00;
            m_ref = 1'b0;
        end
    endtask

    task automatic put(input bit ex, input logic [7:0] b, input logic [7:0] cmd,
                       input logic [7:0] hi);
        byte_vld = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_vld = 1'b0;
        model_edge(ex, cmd, hi, b);
    endtask

    task automatic flag_start();
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
        model_edge(1'b0, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic flag_stop();
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
        model_edge(1'b0, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model_edge(1'b0, 8'h00, 8'h00, 8'h00);
        end
    endtask

    task automatic xact(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] hi,
                        input logic [7:0] lo);
        bit ok;
        ok = (addr == 8'h18);
        flag_start();
        put(1'b0, addr, cmd, hi);
        put(1'b0, cmd, cmd, hi);
        put(1'b0, hi, cmd, hi);
        put(ok, lo, cmd, hi);
        flag_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] cmd;
        string      tag;
        m_inp[0] = '0; m_inp[1] = '0;
        m_dac[0] = '0; m_dac[1] = '0;
        m_mask = 2'b00;
        m_ref = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", 32'(code_a), 32'h0);
        check("R1", 32'(code_b), 32'h0);
        check("R1", 32'(ref_en), 32'h0);

        // R2: foreign address and read form are ignored in full
        xact(8'h1A, 8'b0001_1111, 8'h5A, 8'h50);
        check_all("R2");
        check("R2", 32'(code_a), 32'h0);
        xact(8'h19, 8'b0001_1000, 8'hC3, 8'h30);
        check("R2", 32'(code_a), 32'h0);
        check("R2", 32'(code_b), 32'h0);

        // R3: word assembly and boundary codes
        xact(8'h18, 8'b0001_1000, 8'hAB, 8'hCF);
        check("R3", 32'(code_a), 32'hABC);
        xact(8'h18, 8'b0001_1001, 8'hFF, 8'hFF);
        check("R3", 32'(code_b), 32'hFFF);
        xact(8'h18, 8'b1001_1111, 8'h00, 8'h0F);
        check("R3", 32'(code_a), 32'h000);
        check("R3", 32'(code_b), 32'h000);

        // Sweep of every operation and channel code, load pin high then low (R9 same edge)
        for (int ld = 0; ld < 2; ld++) begin
            ldac_n = (ld == 0);
            for (int c = 0; c < 8; c++) begin
                for (int ch = 0; ch < 8; ch++) begin
                    hi = 8'((c * 29 + ch * 53 + ld * 91 + 7) & 8'hFF);
                    lo = {4'(c * 3 + ch + ld), 4'(ch * 5 + c)};
                    cmd = {1'(c ^ (ch >> 1)), 1'b0, 3'(c), 3'(ch)};
                    xact(8'h18, cmd, hi, lo);
                    if (!(ch == 0 || ch == 1 || ch == 7) && c < 4) tag = "R8";
                    else case (c)
                        0: tag = "R4";
                        1: tag = "R5";
                        2: tag = "R6";
                        3: tag = "R7";
                        5: tag = "R11";
                        6: tag = "R12";
                        default: tag = "R13";
                    endcase
                    if (ld == 1 && c < 4) tag = "R9";
                    check_all(tag);
                end
                if (ld == 0) begin
                    ldac_n = 1'b0;
                    idle(1);
                    ldac_n = 1'b1;
                    check_all("R9");
                end
            end
        end
        ldac_n = 1'b1;

        // R11 then R14: several groups in one transaction
        xact(8'h18, 8'b0010_1000, 8'h00, 8'h00);
        check_all("R11");
        check("R11", 32'(code_a), 32'h0);
        flag_start();
        put(1'b0, 8'h18, 8'h00, 8'h00);
        put(1'b0, 8'b0101_1000, 8'b0101_1000, 8'h00);
        put(1'b0, 8'h12, 8'b0101_1000, 8'h12);
        put(1'b1, 8'h34, 8'b0101_1000, 8'h12);
        check("R14", 32'(code_a), 32'h123);
        put(1'b0, 8'b0101_1001, 8'b0101_1001, 8'h00);
        put(1'b0, 8'h56, 8'b0101_1001, 8'h56);
        put(1'b1, 8'h78, 8'b0101_1001, 8'h56);
        check("R14", 32'(code_b), 32'h567);
        put(1'b0, 8'b0100_0111, 8'b0100_0111, 8'h00);
        put(1'b0, 8'h9A, 8'b0100_0111, 8'h9A);
        put(1'b1, 8'hB0, 8'b0100_0111, 8'h9A);
        check("R4", 32'(code_a), 32'h123);
        flag_stop();
        ldac_n = 1'b0;
        idle(1);
        ldac_n = 1'b1;
        check("R9", 32'(code_a), 32'h9AB);
        check("R9", 32'(code_b), 32'h9AB);

        // R14: single group, trailing bytes discarded
        flag_start();
        put(1'b0, 8'h18, 8'h00, 8'h00);
        put(1'b0, 8'b0001_1000, 8'b0001_1000, 8'h00);
        put(1'b0, 8'h11, 8'b0001_1000, 8'h11);
        put(1'b1, 8'h10, 8'b0001_1000, 8'h11);
        put(1'b0, 8'b0001_1001, 8'h00, 8'h00);
        put(1'b0, 8'h22, 8'h00, 8'h00);
        put(1'b0, 8'h20, 8'h00, 8'h00);
        flag_stop();
        check("R14", 32'(code_a), 32'h111);
        check("R14", 32'(code_b), 32'h9AB);

        // R14: partial group cut by stop
        flag_start();
        put(1'b0, 8'h18, 8'h00, 8'h00);
        put(1'b0, 8'b0001_1000, 8'h00, 8'h00);
        put(1'b0, 8'h77, 8'h00, 8'h00);
        flag_stop();
        put(1'b0, 8'h70, 8'h00, 8'h00);
        check("R14", 32'(code_a), 32'h111);

        // R10: clear is immediate, overrides a same-edge load, keeps inputs
        clr_n = 1'b0;
        #1;
        check("R10", 32'(code_a), 32'h0);
        check("R10", 32'(code_b), 32'h0);
        @(negedge clk);
        model_edge(1'b0, 8'h00, 8'h00, 8'h00);
        xact(8'h18, 8'b0001_1000, 8'h55, 8'h50);
        check("R10", 32'(code_a), 32'h0);
        clr_n = 1'b1;
        idle(1);
        check("R10", 32'(code_a), 32'h0);
        check("R10", 32'(code_b), 32'h0);
        xact(8'h18, 8'b0000_1111, 8'h00, 8'h00);
        check("R5", 32'(code_a), 32'h555);
        check("R5", 32'(code_b), 32'h9AB);

        // R12: channel A transparent, B waits for the pin
        xact(8'h18, 8'b0011_0000, 8'h00, 8'h01);
        xact(8'h18, 8'b0000_0000, 8'h3C, 8'h60);
        check("R12", 32'(code_a), 32'h3C6);
        xact(8'h18, 8'b0000_0001, 8'h4D, 8'h70);
        check("R12", 32'(code_b), 32'h9AB);
        check_all("R12");

        // R13: reference flag, power operation inert
        xact(8'h18, 8'b0011_1000, 8'h00, 8'h01);
        check("R13", 32'(ref_en), 32'h1);
        xact(8'h18, 8'b0010_0111, 8'hEE, 8'hE0);
        check_all("R13");
        check("R13", 32'(ref_en), 32'h1);

        idle(4);
        finish_run();
    end

endmodule